// File: doc/BRIEF.md
# Strobed Port Interrupt Status Controller

This block holds the interrupt status and enable state of a two-port I/O expander. Each of the two 8-bit ports can be set as input or output. When a port is an input, a selected edge (rising or falling) on its strobe pin captures the port pins into a data latch and raises that port's status flag. A combined interrupt flag is raised when a strobing port also has its enable set. A third source, a one-cycle pulse from the nonvolatile memory controller, sets a write-complete flag when its enable is set.

The host reaches everything through a small register bus with four locations: the status/enable register, a configuration register, and the two port data latches. The bus is a plain register interface with no back-pressure: a write or read takes effect at the clock edge where its strobe is high, and read data is combinational from the address. The strobe pins are asynchronous and pass through a synchronizer before edge detection. The memory array, output drivers and the host bus protocol are outside this block.

Top module: `port_irq_ctrl`

## Requirements
- R1: After reset the status register, configuration register and both data latches read 0x00 and `irq` is low.
- R2: The status register (address 0) has, from bit 7 down to bit 0: combined flag, port A status, port B status, port A enable, port B enable, memory-done enable, a bit that always reads 0, memory-done status. The combined flag cannot be set by a write, and writing 1 to any status bit has no effect.
- R3: With a port set as input, the edge chosen by its edge-select bit (1 = rising, 0 = falling) on its strobe sets its status flag and copies its pins into the latch at address 2 (port A) or 3 (port B); the other edge does nothing. Configuration register (address 1): bit 0 port A direction, bit 1 port B direction (1 = output), bit 2 port A edge-select, bit 3 port B edge-select.
- R4: A port set as output ignores its strobe: neither its status flag nor its latch changes.
- R5: The combined flag sets only when a strobing port's enable is 1; with enable 0 the port's status flag still sets but the combined flag does not.
- R6: A read of either data latch clears the combined flag.
- R7: Writing 0 to a set port status flag clears that flag and the combined flag.
- R8: A prog-done pulse sets memory-done status only when its enable is 1; the status stays set until software writes 0 to bit 0.
- R9: `irq` is high exactly when the combined flag is set or memory-done status and its enable are both 1.
- R10: A strobe edge detected in the same cycle as a clearing write or latch read leaves the flags set.
- R11: A strobe pin change is reflected in the flags at the third rising clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| strb_a | input | 1 | Port A strobe pin (asynchronous) |
| strb_b | input | 1 | Port B strobe pin (asynchronous) |
| pins_a | input | 8 | Port A pins |
| pins_b | input | 8 | Port B pins |
| prog_done | input | 1 | One-cycle pulse at end of a memory programming cycle |
| irq | output | 1 | Interrupt request, active high |

## Verification
The strobe edge that sets a port flag can land in the same cycle as the host clearing that flag, either by writing 0 to the status bit or by reading a latch. The bench provokes this by toggling a strobe and placing the clearing access exactly two edges later, so the synchronized edge and the bus access meet at the third edge. The outcome is judged by reading the status register afterwards, where the port and combined flags must still be set, and by reading the latch to see the newly captured pins.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_DATA_A = 2'd2,
    SEL_DATA_B = 2'd3
  } reg_sel_e;

  localparam int NPORT    = 2;
  localparam int B_INT    = 7;
  localparam int B_STA_A  = 6;
  localparam int B_STA_B  = 5;
  localparam int B_EN_A   = 4;
  localparam int B_EN_B   = 3;
  localparam int B_EN_MEM = 2;
  localparam int B_ZERO   = 1;
  localparam int B_MEM    = 0;
endpackage

// File: rtl/pirq_strobe_edge.sv
module pirq_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_in,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= strb_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  always_comb begin
    if (rise_sel) edge_hit = sync_q[STAGES-1] & ~prev_q;
    else          edge_hit = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/pirq_status.sv
module pirq_status
  import pirq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] fire,
  input  logic             prog_done,
  input  logic             wr_status,
  input  logic [REG_W-1:0] wdata,
  input  logic             rd_latch,
  output logic [REG_W-1:0] status_q,
  output logic             irq
);
  logic int_f, sta_a, sta_b, en_a, en_b, en_mem, mem_done;
  logic clr_a, clr_b, clr_mem, set_int, clr_int;

  always_comb begin
    clr_a   = wr_status & ~wdata[B_STA_A];
    clr_b   = wr_status & ~wdata[B_STA_B];
    clr_mem = wr_status & ~wdata[B_MEM];
    set_int = (fire[0] & en_a) | (fire[1] & en_b);
    clr_int = rd_latch | (clr_a & sta_a) | (clr_b & sta_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_f    <= 1'b0;
      sta_a    <= 1'b0;
      sta_b    <= 1'b0;
      en_a     <= 1'b0;
      en_b     <= 1'b0;
      en_mem   <= 1'b0;
      mem_done <= 1'b0;
    end else begin
      if (wr_status) begin
        en_a   <= wdata[B_EN_A];
        en_b   <= wdata[B_EN_B];
        en_mem <= wdata[B_EN_MEM];
      end
      sta_a    <= fire[0] | (sta_a & ~clr_a);
      sta_b    <= fire[1] | (sta_b & ~clr_b);
      mem_done <= (prog_done & en_mem) | (mem_done & ~clr_mem);
      int_f    <= set_int | (int_f & ~clr_int);
    end
  end

  always_comb begin
    status_q           = '0;
    status_q[B_INT]    = int_f;
    status_q[B_STA_A]  = sta_a;
    status_q[B_STA_B]  = sta_b;
    status_q[B_EN_A]   = en_a;
    status_q[B_EN_B]   = en_b;
    status_q[B_EN_MEM] = en_mem;
    status_q[B_MEM]    = mem_done;
    irq                = int_f | (mem_done & en_mem);
  end
endmodule

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic [DATA_W-1:0] pins_a,
  input  logic [DATA_W-1:0] pins_b,
  input  logic              prog_done,
  output logic              irq
);
  localparam int CFG_W = 2 * NPORT;

  logic [CFG_W-1:0]  cfg_q;
  logic [NPORT-1:0]  strb_in;
  logic [NPORT-1:0]  fire;
  logic [NPORT-1:0]  hit;
  logic [DATA_W-1:0] pins [NPORT];
  logic [DATA_W-1:0] lat_q [NPORT];
  logic [7:0]        status_q;
  logic              wr_status, wr_cfg, rd_latch;
  reg_sel_e          sel;

  assign sel       = reg_sel_e'(bus_addr);
  assign wr_status = bus_wr & (sel == SEL_STATUS);
  assign wr_cfg    = bus_wr & (sel == SEL_CFG);
  assign rd_latch  = bus_rd & ((sel == SEL_DATA_A) | (sel == SEL_DATA_B));
  assign strb_in   = {strb_b, strb_a};
  assign pins[0]   = pins_a;
  assign pins[1]   = pins_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pirq_strobe_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb_in (strb_in[p]),
      .rise_sel(cfg_q[NPORT + p]),
      .edge_hit(hit[p])
    );
    assign fire[p] = hit[p] & ~cfg_q[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lat_q[p] <= '0;
      else if (fire[p]) lat_q[p] <= pins[p];
    end
  end

  pirq_status #(.REG_W(8)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .prog_done(prog_done),
    .wr_status(wr_status),
    .wdata    (bus_wdata),
    .rd_latch (rd_latch),
    .status_q (status_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_STATUS: bus_rdata = status_q;
      SEL_CFG:    bus_rdata[CFG_W-1:0] = cfg_q;
      SEL_DATA_A: bus_rdata[DATA_W-1:0] = lat_q[0];
      SEL_DATA_B: bus_rdata[DATA_W-1:0] = lat_q[1];
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [1:0]        fire,
  input logic              prog_done,
  input logic [7:0]        status_q,
  input logic [DATA_W-1:0] lat_a,
  input logic              irq
);
  // R2: the spare bit reads 0 whenever the status register is selected
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[1] == 1'b0));

  // R3/R4: port A flag can only rise through a qualified strobe
  a_r3_sta_a_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[6] && !fire[0]) |=> !status_q[6]);

  // R3/R4: port A latch holds unless a qualified strobe fires
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire[0] |=> $stable(lat_a));

  // R5: combined flag rises only with an enabled strobing port
  a_r5_int_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[7] && !(fire[0] && status_q[4]) && !(fire[1] && status_q[3]))
      |=> !status_q[7]);

  // R8: memory-done stays set unless software writes 0 to bit 0
  a_r8_mem_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[0])) |=> status_q[0]);

  // R8: memory-done does not set while its enable is low
  a_r8_mem_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[0] && !status_q[2]) |=> !status_q[0]);

  // R10: a qualified strobe always leaves its port flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire[1] |=> status_q[5]);

  // R9: memory-done with its enable drives the request
  a_r9_irq_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && status_q[2]) |-> irq);
endmodule

bind port_irq_ctrl pirq_checker #(.DATA_W(DATA_W)) i_pirq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .fire     (fire),
  .prog_done(prog_done),
  .status_q (status_q),
  .lat_a    (lat_q[0]),
  .irq      (irq)
);

// File: tb/test_port_irq_ctrl.sv
`timescale 1ns/1ps
module test_port_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       strb_a = 1'b0, strb_b = 1'b0;
  logic [7:0] pins_a = '0, pins_b = '0;
  logic       prog_done = 1'b0;
  logic       irq;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  port_irq_ctrl i_port_irq_ctrl (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    step(1);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(2'd0, v); check("R1 status", v, 8'h00);
    peek(2'd1, v); check("R1 cfg", v, 8'h00);
    peek(2'd2, v); check("R1 latch A", v, 8'h00);
    peek(2'd3, v); check("R1 latch B", v, 8'h00);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_rise_a;
    logic [7:0] v;
    wr_reg(2'd1, 8'h04);
    wr_reg(2'd0, 8'h10);
    pins_a = 8'h5A;
    strb_a = 1'b1;
    step(2);
    check("R11 irq before third edge", irq, 1'b0);
    step(1);
    check("R11 irq at third edge", irq, 1'b1);
    pins_a = 8'h00;
    peek(2'd0, v); check("R3 R5 status after rise", v, 8'hD0);
    rd_reg(2'd2, v); check("R3 latch A", v, 8'h5A);
    peek(2'd0, v); check("R6 combined cleared by latch read", v, 8'h50);
    check("R6 irq low", irq, 1'b0);
    strb_a = 1'b0;
    step(4);
    peek(2'd0, v); check("R3 falling edge ignored", v, 8'h50);
    wr_reg(2'd0, 8'h10);
    peek(2'd0, v); check("R7 write 0 clears port flag", v, 8'h10);
  endtask

  task automatic t_masked_b;
    logic [7:0] v;
    wr_reg(2'd1, 8'h0C);
    pins_b = 8'hC3;
    strb_b = 1'b1;
    step(4);
    peek(2'd0, v); check("R5 masked port sets only its flag", v, 8'h30);
    check("R5 irq low while masked", irq, 1'b0);
    rd_reg(2'd3, v); check("R3 latch B", v, 8'hC3);
    wr_reg(2'd0, 8'hFF);
    peek(2'd0, v); check("R2 writing ones sets no status", v, 8'h3C);
    wr_reg(2'd0, 8'h1C);
    peek(2'd0, v); check("R7 clear B flag", v, 8'h1C);
  endtask

  task automatic t_output_dir;
    logic [7:0] v;
    wr_reg(2'd1, 8'h0D);
    pins_a = 8'hFF;
    strb_a = 1'b1;
    step(4);
    peek(2'd0, v); check("R4 output port no flag", v, 8'h1C);
    peek(2'd2, v); check("R4 output port latch kept", v, 8'h5A);
    strb_a = 1'b0;
    step(4);
  endtask

  task automatic t_falling;
    logic [7:0] v;
    wr_reg(2'd1, 8'h08);
    strb_a = 1'b1;
    step(4);
    peek(2'd0, v); check("R3 rise ignored with falling select", v, 8'h1C);
    pins_a = 8'h81;
    strb_a = 1'b0;
    step(4);
    peek(2'd0, v); check("R3 falling edge fires", v, 8'hDC);
    check("R9 irq from combined flag", irq, 1'b1);
    peek(2'd2, v); check("R3 falling latch", v, 8'h81);
    wr_reg(2'd0, 8'h1C);
    peek(2'd0, v); check("R7 write 0 clears combined", v, 8'h1C);
    check("R7 irq low", irq, 1'b0);
  endtask

  task automatic t_mem;
    logic [7:0] v;
    wr_reg(2'd0, 8'h18);
    prog_done = 1'b1; step(1); prog_done = 1'b0; step(1);
    peek(2'd0, v); check("R8 masked prog-done", v, 8'h18);
    check("R8 irq low masked", irq, 1'b0);
    wr_reg(2'd0, 8'h1C);
    prog_done = 1'b1; step(1); prog_done = 1'b0; step(1);
    peek(2'd0, v); check("R8 prog-done sets", v, 8'h1D);
    check("R9 irq from memory-done", irq, 1'b1);
    wr_reg(2'd0, 8'h19);
    peek(2'd0, v); check("R9 enable off keeps status", v, 8'h19);
    check("R9 irq low when disabled", irq, 1'b0);
    wr_reg(2'd0, 8'h1D);
    step(10);
    peek(2'd0, v); check("R8 no auto clear", v, 8'h1D);
    check("R9 irq high again", irq, 1'b1);
    wr_reg(2'd0, 8'h1C);
    peek(2'd0, v); check("R8 software clear", v, 8'h1C);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    wr_reg(2'd1, 8'h0C);
    strb_b = 1'b0;
    step(4);
    pins_b = 8'h3C;
    strb_b = 1'b1;
    step(4);
    peek(2'd0, v); check("R5 enabled B sets combined", v, 8'hBC);
    strb_b = 1'b0;
    step(4);
    pins_b = 8'h77;
    strb_b = 1'b1;
    step(2);
    wr_reg(2'd0, 8'h1C);
    peek(2'd0, v); check("R10 set wins over write clear", v, 8'hBC);
    wr_reg(2'd0, 8'h1C);
    peek(2'd0, v); check("R7 clear before read collision", v, 8'h1C);
    strb_b = 1'b0;
    step(4);
    pins_b = 8'h66;
    strb_b = 1'b1;
    step(2);
    rd_reg(2'd3, v); check("R10 read returns old latch", v, 8'h77);
    peek(2'd0, v); check("R10 set wins over read clear", v, 8'hBC);
    peek(2'd3, v); check("R10 new latch data", v, 8'h66);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_rise_a();
    t_masked_b();
    t_output_dir();
    t_falling();
    t_mem();
    t_collision();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule